// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

The doorbell unit lets bus masters signal one another without carrying any data. It holds a row of doorbells, each owned by one receiving master. Any master rings a doorbell by writing the value one to that doorbell's trigger word. The bus tags every access with the issuing master's ID, and that ID selects the bit that the ring records.

Each doorbell keeps three bitmaps, each indexed by source master ID. The permit map chooses which masters may ring it. The history map records every ring, whether it was permitted or not. The pending map latches only permitted rings and drives the doorbell's level interrupt. The receiver clears pending or history bits by writing back the value it read, which is write-one-to-clear. Several bus ports reach the unit in the same cycle. A ring and a clear that meet on the same bit leave that bit set, so no ring is lost.

The unit is built from plain set/clear registers and has no sequencing state machine. Each port has a decoder, each doorbell has a register cell, and each port has a registered read path.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every permit, history and pending bit is zero, every `db_irq` bit is low and every `bus_rvalid` bit is low.
- R2: Doorbell d occupies byte addresses d*0x100 to d*0x100+0xFF. Its trigger word is at +0x0, permit at +0x4, history at +0x8 and pending at +0xC. A read returns the NUM_MASTERS-bit map zero-extended, and a read of the trigger word returns 0. Any other offset, and any address whose low two bits are not zero, reads 0 and ignores writes.
- R3: A write of exactly 1 to a trigger word by master m sets history bit m in the next cycle. A write of any other value to a trigger word changes nothing.
- R4: A ring by master m whose permit bit m is set at the time of the ring sets pending bit m in the next cycle.
- R5: A ring by a master whose permit bit is clear sets only the history bit. Setting the permit bit later does not raise the pending bit.
- R6: `db_irq[d]` is high exactly while doorbell d has any pending bit set.
- R7: A write to the pending word or the history word clears each bit written as one and leaves every other bit of that map unchanged.
- R8: A write to the permit word replaces the whole map, so single bits can be changed by read-modify-write. When two ports write the same permit word in one cycle, the higher-numbered port's value is kept.
- R9: When a ring and a clear hit the same pending or history bit in one cycle, the bit ends up set.
- R10: A read raises `bus_rvalid` for exactly the next cycle, with the data the register held before any write made in the read's own cycle.
- R11: Accesses to a doorbell index of NUM_DB or above are ignored, and an access to one doorbell leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | NUM_PORTS | Access request, one bit per port |
| bus_we | input | NUM_PORTS | 1 = write, 0 = read, per port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per port |
| bus_wdata | input | NUM_PORTS*DATA_W | Write data per port |
| bus_mid | input | NUM_PORTS*$clog2(NUM_MASTERS) | Issuing master ID per port |
| bus_rdata | output | NUM_PORTS*DATA_W | Read data per port, valid with bus_rvalid |
| bus_rvalid | output | NUM_PORTS | Read data valid, one cycle after a read |
| db_irq | output | NUM_DB | Level interrupt per doorbell |

## Verification
The assertions check four things on every cycle. A permitted ring always reaches pending. A new pending bit only ever comes from a permitted ring. Every ring reaches history. An interrupt can fall only after a pending clear. The read path asserts the one-cycle valid timing. The bench scenarios cover what the assertions cannot express on their own: the address map with its ignored offsets, the rule that a value other than one on the trigger word does not ring, the later permit that raises nothing, the choice between two same-cycle permit writes, and the isolation between doorbells. A behavioural reference model checks all of these against random two-port traffic on every clock.

// File: rtl/db_pkg.sv
package db_pkg;
    // Register selected by address bits [3:2] inside a doorbell's window.
    typedef enum logic [1:0] {
        REG_TRIG = 2'd0,
        REG_PERM = 2'd1,
        REG_HIST = 2'd2,
        REG_PEND = 2'd3
    } db_reg_e;

    // Doorbell windows are 256 bytes apart.
    localparam int DB_WIN_LSB = 8;
endpackage

// File: rtl/db_port_decode.sv
module db_port_decode
    import db_pkg::*;
#(
    parameter int NUM_DB      = 8,
    parameter int NUM_MASTERS = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32
) (
    input  logic                                  req,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                     wdata,
    input  logic [$clog2(NUM_MASTERS)-1:0]        mid,
    output logic [NUM_DB-1:0][NUM_MASTERS-1:0]    ring,
    output logic [NUM_DB-1:0]                     perm_we,
    output logic [NUM_MASTERS-1:0]                perm_wd,
    output logic [NUM_DB-1:0][NUM_MASTERS-1:0]    hist_clr,
    output logic [NUM_DB-1:0][NUM_MASTERS-1:0]    pend_clr,
    output logic                                  rd_en,
    output logic                                  rd_hit,
    output logic [ADDR_W-DB_WIN_LSB-1:0]          rd_idx,
    output db_reg_e                               rd_sel
);
    localparam int IDX_W = ADDR_W - DB_WIN_LSB;

    logic [IDX_W-1:0] idx;
    db_reg_e          sel;
    logic             hit;

    always_comb begin
        idx = addr[ADDR_W-1:DB_WIN_LSB];
        sel = db_reg_e'(addr[3:2]);
        hit = req && (addr[DB_WIN_LSB-1:4] == '0) && (addr[1:0] == 2'd0)
              && (int'(idx) < NUM_DB);
        ring     = '0;
        perm_we  = '0;
        hist_clr = '0;
        pend_clr = '0;
        for (int d = 0; d < NUM_DB; d++) begin
            if (hit && we && (int'(idx) == d)) begin
                unique case (sel)
                    REG_TRIG: if (wdata == DATA_W'(1)) ring[d] = NUM_MASTERS'(1) << mid;
                    REG_PERM: perm_we[d] = 1'b1;
                    REG_HIST: hist_clr[d] = wdata[NUM_MASTERS-1:0];
                    REG_PEND: pend_clr[d] = wdata[NUM_MASTERS-1:0];
                endcase
            end
        end
    end

    assign perm_wd = wdata[NUM_MASTERS-1:0];
    assign rd_en   = req && !we;
    assign rd_hit  = hit;
    assign rd_idx  = idx;
    assign rd_sel  = sel;
endmodule

// File: rtl/db_cell.sv
module db_cell #(
    parameter int NUM_PORTS   = 2,
    parameter int NUM_MASTERS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]  ring,
    input  logic [NUM_PORTS-1:0]                   perm_we,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]  perm_wd,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]  hist_clr,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]  pend_clr,
    output logic [NUM_MASTERS-1:0]                 perm_q,
    output logic [NUM_MASTERS-1:0]                 hist_q,
    output logic [NUM_MASTERS-1:0]                 pend_q,
    output logic                                   irq
);
    logic [NUM_MASTERS-1:0] ring_any, hclr_any, pclr_any, perm_n;

    always_comb begin
        ring_any = '0;
        hclr_any = '0;
        pclr_any = '0;
        perm_n   = perm_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            ring_any |= ring[p];
            hclr_any |= hist_clr[p];
            pclr_any |= pend_clr[p];
            if (perm_we[p]) perm_n = perm_wd[p];   // later port overrides earlier
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_q <= '0;
            hist_q <= '0;
            pend_q <= '0;
        end else begin
            perm_q <= perm_n;
            hist_q <= (hist_q & ~hclr_any) | ring_any;
            pend_q <= (pend_q & ~pclr_any) | (ring_any & perm_q);
        end
    end

    assign irq = |pend_q;

    // R4 / R9: a permitted ring always lands in pending, even against a clear
    p_permitted_ring_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(ring_any & perm_q)) == $past(ring_any & perm_q)));

    // R5: a pending bit can only rise for a master permitted in the previous cycle
    p_unpermitted_stays_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(perm_q)) == '0));

    // R3 / R9: every ring is kept in history
    p_history_records_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hist_q & $past(ring_any)) == $past(ring_any)));

    // R7: the interrupt drops only after a pending clear
    p_irq_falls_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(pclr_any != '0));
endmodule

// File: rtl/db_read_port.sv
module db_read_port
    import db_pkg::*;
#(
    parameter int NUM_DB      = 8,
    parameter int NUM_MASTERS = 8,
    parameter int IDX_W       = 4,
    parameter int DATA_W      = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_en,
    input  logic                                rd_hit,
    input  logic [IDX_W-1:0]                    rd_idx,
    input  db_reg_e                             rd_sel,
    input  logic [NUM_DB-1:0][NUM_MASTERS-1:0]  perm_all,
    input  logic [NUM_DB-1:0][NUM_MASTERS-1:0]  hist_all,
    input  logic [NUM_DB-1:0][NUM_MASTERS-1:0]  pend_all,
    output logic [DATA_W-1:0]                   rdata,
    output logic                                rvalid
);
    logic [NUM_MASTERS-1:0] val;

    always_comb begin
        val = '0;
        for (int d = 0; d < NUM_DB; d++) begin
            if (int'(rd_idx) == d) begin
                unique case (rd_sel)
                    REG_TRIG: val = '0;
                    REG_PERM: val = perm_all[d];
                    REG_HIST: val = hist_all[d];
                    REG_PEND: val = pend_all[d];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= (rd_en && rd_hit) ? DATA_W'(val) : '0;
        end
    end

    // R10: valid follows a read by exactly one cycle
    p_read_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    p_no_stray_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import db_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int NUM_DB      = 8,
    parameter int NUM_MASTERS = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NUM_PORTS-1:0]                     bus_req,
    input  logic [NUM_PORTS-1:0]                     bus_we,
    input  logic [NUM_PORTS*ADDR_W-1:0]              bus_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]              bus_wdata,
    input  logic [NUM_PORTS*$clog2(NUM_MASTERS)-1:0] bus_mid,
    output logic [NUM_PORTS*DATA_W-1:0]              bus_rdata,
    output logic [NUM_PORTS-1:0]                     bus_rvalid,
    output logic [NUM_DB-1:0]                        db_irq
);
    localparam int MID_W = $clog2(NUM_MASTERS);
    localparam int IDX_W = ADDR_W - DB_WIN_LSB;

    logic [NUM_PORTS-1:0][NUM_DB-1:0][NUM_MASTERS-1:0] ring_pd, hclr_pd, pclr_pd;
    logic [NUM_PORTS-1:0][NUM_DB-1:0]                  pwe_pd;
    logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]             pwd_p;
    logic [NUM_DB-1:0][NUM_PORTS-1:0][NUM_MASTERS-1:0] ring_dp, hclr_dp, pclr_dp;
    logic [NUM_DB-1:0][NUM_PORTS-1:0]                  pwe_dp;
    logic [NUM_DB-1:0][NUM_MASTERS-1:0]                perm_all, hist_all, pend_all;
    logic [NUM_PORTS-1:0]                              rd_en_p, rd_hit_p;
    logic [NUM_PORTS-1:0][IDX_W-1:0]                   rd_idx_p;
    db_reg_e                                           rd_sel_p [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        db_port_decode #(
            .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS),
            .ADDR_W(ADDR_W), .DATA_W(DATA_W)
        ) u_dec (
            .req      (bus_req[p]),
            .we       (bus_we[p]),
            .addr     (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata    (bus_wdata[p*DATA_W +: DATA_W]),
            .mid      (bus_mid[p*MID_W +: MID_W]),
            .ring     (ring_pd[p]),
            .perm_we  (pwe_pd[p]),
            .perm_wd  (pwd_p[p]),
            .hist_clr (hclr_pd[p]),
            .pend_clr (pclr_pd[p]),
            .rd_en    (rd_en_p[p]),
            .rd_hit   (rd_hit_p[p]),
            .rd_idx   (rd_idx_p[p]),
            .rd_sel   (rd_sel_p[p])
        );

        db_read_port #(
            .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS),
            .IDX_W(IDX_W), .DATA_W(DATA_W)
        ) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (rd_en_p[p]),
            .rd_hit   (rd_hit_p[p]),
            .rd_idx   (rd_idx_p[p]),
            .rd_sel   (rd_sel_p[p]),
            .perm_all (perm_all),
            .hist_all (hist_all),
            .pend_all (pend_all),
            .rdata    (bus_rdata[p*DATA_W +: DATA_W]),
            .rvalid   (bus_rvalid[p])
        );

        for (genvar d = 0; d < NUM_DB; d++) begin : g_swap
            assign ring_dp[d][p] = ring_pd[p][d];
            assign hclr_dp[d][p] = hclr_pd[p][d];
            assign pclr_dp[d][p] = pclr_pd[p][d];
            assign pwe_dp[d][p]  = pwe_pd[p][d];
        end
    end

    for (genvar d = 0; d < NUM_DB; d++) begin : g_db
        db_cell #(
            .NUM_PORTS(NUM_PORTS), .NUM_MASTERS(NUM_MASTERS)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ring     (ring_dp[d]),
            .perm_we  (pwe_dp[d]),
            .perm_wd  (pwd_p),
            .hist_clr (hclr_dp[d]),
            .pend_clr (pclr_dp[d]),
            .perm_q   (perm_all[d]),
            .hist_q   (hist_all[d]),
            .pend_q   (pend_all[d]),
            .irq      (db_irq[d])
        );
    end
endmodule

// File: tb/doorbell_unit_bench.sv
module doorbell_unit_bench;
    localparam int CLK_P = 10;
    localparam int NP = 2, NDB = 8, NM = 8, AW = 12, DW = 32;
    localparam int MW = $clog2(NM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [NP-1:0]    b_req, b_we;
    logic [NP*AW-1:0] b_addr;
    logic [NP*DW-1:0] b_wd;
    logic [NP*MW-1:0] b_mid;
    logic [NP*DW-1:0] b_rdata;
    logic [NP-1:0]    b_rvalid;
    logic [NDB-1:0]   irq_v;

    logic          t_req [NP];
    logic          t_we  [NP];
    logic [AW-1:0] t_addr[NP];
    logic [DW-1:0] t_wd  [NP];
    logic [MW-1:0] t_mid [NP];

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            b_req[p]            = t_req[p];
            b_we[p]             = t_we[p];
            b_addr[p*AW +: AW]  = t_addr[p];
            b_wd[p*DW +: DW]    = t_wd[p];
            b_mid[p*MW +: MW]   = t_mid[p];
        end
    end

    doorbell_unit #(.NUM_PORTS(NP), .NUM_DB(NDB), .NUM_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW))
    u_doorbell_unit (
        .clk(clk), .rst_n(rst_n), .bus_req(b_req), .bus_we(b_we), .bus_addr(b_addr),
        .bus_wdata(b_wd), .bus_mid(b_mid), .bus_rdata(b_rdata), .bus_rvalid(b_rvalid),
        .db_irq(irq_v)
    );

    // reference model state
    logic [NM-1:0] m_perm[NDB], m_hist[NDB], m_pend[NDB];
    logic          e_rv[NP];
    logic [DW-1:0] e_rd[NP];
    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        for (int p = 0; p < NP; p++) begin
            t_req[p] = 1'b0; t_we[p] = 1'b0; t_addr[p] = '0; t_wd[p] = '0; t_mid[p] = '0;
        end
    endtask

    task automatic model_edge();
        logic [NM-1:0] ring[NDB], hc[NDB], pc[NDB], np[NDB];
        for (int d = 0; d < NDB; d++) begin
            ring[d] = '0; hc[d] = '0; pc[d] = '0; np[d] = m_perm[d];
        end
        for (int p = 0; p < NP; p++) begin
            int d, off;
            bit ok;
            d   = int'(t_addr[p]) / 256;
            off = int'(t_addr[p]) % 256;
            ok  = t_req[p] && d < NDB && (off == 0 || off == 4 || off == 8 || off == 12);
            e_rv[p] = t_req[p] && !t_we[p];
            e_rd[p] = '0;
            if (ok && !t_we[p]) begin
                if (off == 4)  e_rd[p] = DW'(m_perm[d]);
                if (off == 8)  e_rd[p] = DW'(m_hist[d]);
                if (off == 12) e_rd[p] = DW'(m_pend[d]);
            end
            if (ok && t_we[p]) begin
                if (off == 0 && t_wd[p] == 1) ring[d][t_mid[p]] = 1'b1;
                if (off == 4)  np[d] = t_wd[p][NM-1:0];
                if (off == 8)  hc[d] |= t_wd[p][NM-1:0];
                if (off == 12) pc[d] |= t_wd[p][NM-1:0];
            end
        end
        for (int d = 0; d < NDB; d++) begin
            m_hist[d] = (m_hist[d] & ~hc[d]) | ring[d];
            m_pend[d] = (m_pend[d] & ~pc[d]) | (ring[d] & m_perm[d]);
            m_perm[d] = np[d];
        end
    endtask

    task automatic step();
        logic [NDB-1:0] ei;
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        for (int d = 0; d < NDB; d++) ei[d] = (m_pend[d] != '0);
        check(irq_v == ei, "R6", "irq vector", 32'(irq_v), 32'(ei));
        for (int p = 0; p < NP; p++) begin
            check(b_rvalid[p] == e_rv[p], "R10", "rvalid", 32'(b_rvalid[p]), 32'(e_rv[p]));
            check(b_rdata[p*DW +: DW] == e_rd[p], "R10", "rdata vs model",
                  b_rdata[p*DW +: DW], e_rd[p]);
        end
        clear_in();
    endtask

    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] v,
                      input logic [MW-1:0] m);
        t_req[p] = 1'b1; t_we[p] = 1'b1; t_addr[p] = a; t_wd[p] = v; t_mid[p] = m;
        step();
    endtask

    task automatic rd_chk(input int p, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input string tag);
        t_req[p] = 1'b1; t_we[p] = 1'b0; t_addr[p] = a;
        step();
        check(b_rdata[p*DW +: DW] == exp, tag, $sformatf("read %h", a), b_rdata[p*DW +: DW], exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        check(1'b0, "WATCHDOG", "timeout", 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int d = 0; d < NDB; d++) begin m_perm[d] = '0; m_hist[d] = '0; m_pend[d] = '0; end
        for (int p = 0; p < NP; p++) begin e_rv[p] = 1'b0; e_rd[p] = '0; end
        clear_in();
        repeat (3) @(negedge clk);
        check(irq_v == '0, "R1", "irq in reset", 32'(irq_v), 0);
        check(b_rvalid == '0, "R1", "rvalid in reset", 32'(b_rvalid), 0);
        rst_n = 1'b1;
        step();
        rd_chk(0, 12'h104, 0, "R1");
        rd_chk(1, 12'h108, 0, "R1");
        rd_chk(0, 12'h10C, 0, "R1");

        // R2 address map
        wr(0, 12'h204, 32'h5A, 0);
        rd_chk(0, 12'h204, 32'h5A, "R2");
        rd_chk(1, 12'h200, 0, "R2");
        wr(0, 12'h214, 32'hFF, 0);
        wr(0, 12'h206, 32'hFF, 0);
        rd_chk(0, 12'h204, 32'h5A, "R2");
        rd_chk(0, 12'h214, 0, "R2");

        // R3 / R5: unpermitted ring lands in history only
        wr(1, 12'h100, 1, 3);
        rd_chk(0, 12'h108, 32'h08, "R3");
        rd_chk(0, 12'h10C, 0, "R5");
        wr(0, 12'h100, 2, 5);
        wr(0, 12'h100, 32'h101, 6);
        rd_chk(0, 12'h108, 32'h08, "R3");
        wr(0, 12'h104, 32'h08, 0);
        rd_chk(0, 12'h10C, 0, "R5");
        check(irq_v[1] == 1'b0, "R5", "irq after late permit", 32'(irq_v[1]), 0);

        // R4 / R6: permitted ring
        wr(1, 12'h100, 1, 3);
        check(irq_v[1] == 1'b1, "R6", "irq after ring", 32'(irq_v[1]), 1);
        rd_chk(0, 12'h10C, 32'h08, "R4");

        // R8 read-modify-write of permit
        rd_chk(0, 12'h104, 32'h08, "R8");
        wr(0, 12'h104, 32'h28, 0);
        rd_chk(1, 12'h104, 32'h28, "R8");

        // R7 write-one-to-clear
        wr(0, 12'h100, 1, 5);
        rd_chk(0, 12'h10C, 32'h28, "R4");
        wr(0, 12'h10C, 32'h08, 0);
        rd_chk(0, 12'h10C, 32'h20, "R7");
        check(irq_v[1] == 1'b1, "R7", "irq with bit left", 32'(irq_v[1]), 1);
        wr(1, 12'h108, 32'h08, 0);
        rd_chk(0, 12'h108, 32'h20, "R7");
        rd_chk(0, 12'h10C, 32'h20, "R7");

        // R9 ring against clear in the same cycle
        t_req[0] = 1; t_we[0] = 1; t_addr[0] = 12'h100; t_wd[0] = 1; t_mid[0] = 5;
        t_req[1] = 1; t_we[1] = 1; t_addr[1] = 12'h10C; t_wd[1] = 32'h20;
        step();
        rd_chk(0, 12'h10C, 32'h20, "R9");
        t_req[0] = 1; t_we[0] = 1; t_addr[0] = 12'h100; t_wd[0] = 1; t_mid[0] = 5;
        t_req[1] = 1; t_we[1] = 1; t_addr[1] = 12'h108; t_wd[1] = 32'h20;
        step();
        rd_chk(0, 12'h108, 32'h20, "R9");
        wr(1, 12'h10C, 32'hFF, 0);
        check(irq_v[1] == 1'b0, "R7", "irq after full clear", 32'(irq_v[1]), 0);

        // R8 two ports on one permit word
        t_req[0] = 1; t_we[0] = 1; t_addr[0] = 12'h404; t_wd[0] = 32'h11;
        t_req[1] = 1; t_we[1] = 1; t_addr[1] = 12'h404; t_wd[1] = 32'h22;
        step();
        rd_chk(0, 12'h404, 32'h22, "R8");
        wr(0, 12'h104, 32'h28 & ~32'h08, 0);
        rd_chk(0, 12'h104, 32'h20, "R8");

        // R11 out-of-range and isolation
        wr(0, 12'h800, 1, 2);
        check(irq_v == '0, "R11", "irq after out-of-range ring", 32'(irq_v), 0);
        wr(0, 12'h300, 1, 2);
        rd_chk(0, 12'h108, 32'h20, "R11");
        rd_chk(1, 12'h308, 32'h04, "R11");

        // R10 read sees pre-write value
        t_req[0] = 1; t_we[0] = 1; t_addr[0] = 12'h504; t_wd[0] = 32'h77;
        t_req[1] = 1; t_we[1] = 0; t_addr[1] = 12'h504;
        step();
        check(b_rdata[DW +: DW] == 0, "R10", "same-cycle read", b_rdata[DW +: DW], 0);
        step();
        check(b_rvalid == '0, "R10", "valid one cycle only", 32'(b_rvalid), 0);
        rd_chk(1, 12'h504, 32'h77, "R10");

        // random two-port traffic against the model
        for (int i = 0; i < 600; i++) begin
            for (int p = 0; p < NP; p++) begin
                int d, sel;
                d   = $urandom_range(0, NDB);
                sel = $urandom_range(0, 4);
                t_req[p]  = ($urandom_range(0, 9) < 7);
                t_we[p]   = $urandom_range(0, 1);
                t_addr[p] = AW'(d * 256 + ((sel == 4) ? 16 : sel * 4));
                t_wd[p]   = (sel == 0 && $urandom_range(0, 3) != 0) ? 32'd1 : 32'($urandom);
                t_mid[p]  = MW'($urandom_range(0, NM - 1));
            end
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule